// File: doc/BRIEF.md
# Banked Per-Pin Pad Configuration Controller

This block holds the configuration of a row of general-purpose pads and turns it into pad control signals. Every pin owns exactly one 8-bit register address. Behind that address sit six hidden 4-bit banks. The banks are reached indirectly: a write whose top bit is clear only moves the pin's read pointer to a bank. A write whose top bit is set stores its low nibble into the bank it names. Reading the address returns the bank the pointer currently selects, so software reads with a select-then-read pair of accesses.

From the stored banks, each pin derives the following controls: pad output enable, driven level, bias code and drive strength. It also derives the input level it reports, after any polarity inversion. A separate translator maps external pin numbers, which count from 1, onto internal indices, which count from 0. It rejects numbers that fall outside the pin range.

The register port is a plain strobe interface with no back-pressure. A write completes in the clock edge that samples the write strobe. Read data appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `pcfg_bank_ctrl`

## Requirements
- R1: After reset, every bank of every pin is zero and every read pointer selects bank 0. A read of any valid pin therefore returns 0x00, and every pad output enable is low.
- R2: A write with bit 7 set and bits 6:4 equal to a bank number b from 0 to 5 stores bits 3:0 into bank b of the addressed pin. The read pointer does not change.
- R3: A write with bit 7 clear sets the pin's read pointer to bits 6:4 and stores nothing. Bank numbers 6 and 7 are ignored: a commit to them stores nothing, and a select of them leaves the pointer unchanged.
- R4: A read returns bit 7 = 0, bits 6:4 = the selected bank number and bits 3:0 = that bank's contents. The value appears on reg_rdata after the clock edge that samples reg_rd and holds until the next read.
- R5: Pin k sits at address BASE_ADDR + k, with BASE_ADDR = 0x150 by default. A write to an address outside BASE_ADDR to BASE_ADDR + NUM_PINS − 1 changes nothing, and a read from such an address returns 0x00.
- R6: Bank 1 bits 3:2 form the mode: 0 = input, 1 = both, 2 = output, 3 = off. The output driver can be enabled only when mode bit 1 is set. Bank 3 bit 0 set (disable) forces output enable low in every mode.
- R7: Bank 1 bit 1 selects open-drain. In open-drain mode a driven level of 0 enables the output and a driven level of 1 releases it (output enable low). In push-pull mode the driven level has no effect on output enable.
- R8: Bank 5 bit 3 set means normal polarity and clear means inverted. The driven level pad_out is bank 1 bit 0 XOR inverted, and pin_level is pad_in XOR inverted.
- R9: pad_bias of a pin shows bank 2 bits 3:1 (0 to 3 pull-up variants, 4 pull-down, 5 no pull). pad_drive shows bank 3 bits 3:2 (0 none, 1 high, 2 medium, 3 low).
- R10: An external pin number n is valid only if 1 ≤ n ≤ NUM_PINS. A valid number yields index n − 1; an invalid number yields ext_valid low and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write byte: bit 7 commit, bits 6:4 bank, bits 3:0 data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read byte |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Pad output enable per pin |
| pad_out | output | NUM_PINS | Driven pad level per pin |
| pin_level | output | NUM_PINS | Reported input level after polarity |
| pad_bias | output | 3*NUM_PINS | Bias code, pin k at bits 3k+2:3k |
| pad_drive | output | 2*NUM_PINS | Drive strength, pin k at bits 2k+1:2k |
| ext_pin_num | input | PIN_NUM_W | External pin number, counting from 1 |
| ext_idx | output | PIN_NUM_W | Internal index for ext_pin_num |
| ext_valid | output | 1 | ext_pin_num is within range |

## Verification
The bench targets several mistakes that a faulty design could make:
- A select write that also stores its low nibble would turn a later read of that bank into the stray nibble.
- A commit that also moves the pointer would make the following read return the new bank instead of bank 0.
- Bank numbers 6 and 7 must be ignored. A design that accepts them would show a pointer field of 6 on readback.
- Open-drain and disable handling is checked in every mode. A wrong gating term would leave output enable high while the line should be released.
- Polarity inversion is checked on both the driven and the reported level, since the reset value of bank 5 means inverted.
- The address window and pin-number translation are probed one step inside and one step outside each end. This catches off-by-one bounds.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int NBANKS  = 6;
  localparam int BANK_W  = 3;
  localparam int NIB_W   = 4;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BANK_W-1:0] bank_sel_t;

  typedef enum logic [1:0] {
    MODE_IN   = 2'd0,
    MODE_BOTH = 2'd1,
    MODE_OUT  = 2'd2,
    MODE_OFF  = 2'd3
  } pad_mode_e;

  typedef struct packed {
    logic       commit;
    bank_sel_t  bank;
    nib_t       data;
  } reg_byte_t;
endpackage

// File: rtl/pcfg_pin_xlate.sv
module pcfg_pin_xlate #(
  parameter int NUM_PINS  = 8,
  parameter int PIN_NUM_W = 6
) (
  input  logic [PIN_NUM_W-1:0] num,
  output logic [PIN_NUM_W-1:0] idx,
  output logic                 valid
);
  localparam logic [PIN_NUM_W-1:0] MAX_NUM = PIN_NUM_W'(NUM_PINS);

  always_comb begin
    valid = (num != '0) && (num <= MAX_NUM);
    idx   = valid ? (num - PIN_NUM_W'(1)) : '0;
  end
endmodule

// File: rtl/pcfg_pin_slice.sv
module pcfg_pin_slice
  import pcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wdata,
  output logic [7:0] rd_byte,
  input  logic       pad_in,
  output logic       pad_oe,
  output logic       pad_out,
  output logic       pin_level,
  output logic [2:0] pad_bias,
  output logic [1:0] pad_drive
);
  reg_byte_t wbyte;
  bank_sel_t ptr_q;
  nib_t      bank_q [NBANKS];
  logic      bank_ok;

  assign wbyte   = reg_byte_t'(wdata);
  assign bank_ok = (wbyte.bank < BANK_W'(NBANKS));

  // Storage for each hidden bank.
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[b] <= '0;
      else if (wr_hit && wbyte.commit && wbyte.bank == BANK_W'(b))
        bank_q[b] <= wbyte.data;
    end
  end

  // Read pointer: moved only by select writes naming a real bank.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (wr_hit && !wbyte.commit && bank_ok)
      ptr_q <= wbyte.bank;
  end

  assign rd_byte = {1'b0, ptr_q, bank_q[ptr_q]};

  // Pad control decode.
  pad_mode_e mode;
  logic      od, lvl, dis, inverted, drv_lvl;

  always_comb begin
    mode     = pad_mode_e'(bank_q[1][3:2]);
    od       = bank_q[1][1];
    lvl      = bank_q[1][0];
    dis      = bank_q[3][0];
    inverted = !bank_q[5][3];
    drv_lvl  = lvl ^ inverted;
    pad_out  = drv_lvl;
    pad_oe   = mode[1] && !dis && !(od && drv_lvl);
    pin_level = pad_in ^ inverted;
    pad_bias  = bank_q[2][3:1];
    pad_drive = bank_q[3][3:2];
  end
endmodule

// File: rtl/pcfg_bank_ctrl.sv
module pcfg_bank_ctrl #(
  parameter int              NUM_PINS  = 8,
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h150,
  parameter int              PIN_NUM_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            reg_wdata,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  output logic [7:0]            reg_rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pin_level,
  output logic [3*NUM_PINS-1:0] pad_bias,
  output logic [2*NUM_PINS-1:0] pad_drive,
  input  logic [PIN_NUM_W-1:0]  ext_pin_num,
  output logic [PIN_NUM_W-1:0]  ext_idx,
  output logic                  ext_valid
);
  localparam logic [ADDR_W-1:0] PIN_CNT = ADDR_W'(NUM_PINS);

  logic [ADDR_W-1:0] offs;
  logic              in_win;
  logic [7:0]        slice_rd [NUM_PINS];
  logic [7:0]        rd_mux;

  assign offs   = reg_addr - BASE_ADDR;
  assign in_win = (reg_addr >= BASE_ADDR) && (offs < PIN_CNT);

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    pcfg_pin_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (reg_wr && in_win && offs == ADDR_W'(k)),
      .wdata     (reg_wdata),
      .rd_byte   (slice_rd[k]),
      .pad_in    (pad_in[k]),
      .pad_oe    (pad_oe[k]),
      .pad_out   (pad_out[k]),
      .pin_level (pin_level[k]),
      .pad_bias  (pad_bias[3*k +: 3]),
      .pad_drive (pad_drive[2*k +: 2])
    );
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int k = 0; k < NUM_PINS; k++)
      if (in_win && offs == ADDR_W'(k)) rd_mux = slice_rd[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_rdata <= 8'h00;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end

  pcfg_pin_xlate #(.NUM_PINS(NUM_PINS), .PIN_NUM_W(PIN_NUM_W)) u_xlate (
    .num   (ext_pin_num),
    .idx   (ext_idx),
    .valid (ext_valid)
  );
endmodule

// File: rtl/pcfg_bank_ctrl_chk.sv
module pcfg_bank_ctrl_chk #(
  parameter int              NUM_PINS  = 8,
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h150,
  parameter int              PIN_NUM_W = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_rd,
  input logic [7:0]           reg_rdata,
  input logic [PIN_NUM_W-1:0] ext_pin_num,
  input logic [PIN_NUM_W-1:0] ext_idx,
  input logic                 ext_valid
);
  logic outside;
  assign outside = (int'(reg_addr) < int'(BASE_ADDR)) ||
                   (int'(reg_addr) >= int'(BASE_ADDR) + NUM_PINS);

  assert_rdata_top_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0);

  assert_ptr_real_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:4] <= 3'd5);

  assert_rdata_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  assert_outside_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && outside) |=> reg_rdata == 8'h00);

  assert_xlate_maps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (int'(ext_idx) + 1 == int'(ext_pin_num) && int'(ext_idx) < NUM_PINS));

  assert_xlate_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_pin_num == '0 || int'(ext_pin_num) > NUM_PINS) |-> !ext_valid);
endmodule

bind pcfg_bank_ctrl pcfg_bank_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .PIN_NUM_W(PIN_NUM_W)
) u_chk (.*);

// File: tb/pcfg_bank_ctrl_bench.sv
module pcfg_bank_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int AW = 10;
  localparam int PW = 6;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_rdata;
  logic [NP-1:0] pad_in = '0, pad_oe, pad_out, pin_level;
  logic [3*NP-1:0] pad_bias;
  logic [2*NP-1:0] pad_drive;
  logic [PW-1:0] ext_pin_num = '0, ext_idx;
  logic ext_valid;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_q = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcfg_bank_ctrl u_pcfg_bank_ctrl (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = AW'(a); reg_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 0;
  endtask

  // Monitor: compares read results one edge after the strobe.
  always @(posedge clk) rd_q <= reg_rd;
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, reg_rdata, e);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam int P3 = 'h153;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe after reset", pad_oe, 0);
    chk("R8 reset polarity inverted level", pin_level, 8'hFF);
    rd(P3, 8'h00, "R1 read after reset");
    // R2 commit bias=4 into bank 2, pointer stays at bank 0
    wr(P3, 8'hA8);
    rd(P3, 8'h00, "R2 pointer unchanged by commit");
    chk("R9 bias code", pad_bias[9 +: 3], 4);
    // R3 select bank 2
    wr(P3, 8'h20);
    rd(P3, 8'h28, "R3 select bank 2 readback");
    wr(P3, 8'h60);
    rd(P3, 8'h28, "R3 select bank 6 ignored");
    wr(P3, 8'hFF);
    rd(P3, 8'h28, "R3 commit bank 7 ignored");
    wr(P3, 8'h25);
    rd(P3, 8'h28, "R3 select write stores nothing");
    // R6 output mode, normal polarity
    wr(P3, 8'hD8);
    wr(P3, 8'h99);
    chk("R6 output mode oe", pad_oe[3], 1);
    chk("R8 normal driven level", pad_out[3], 1);
    wr(P3, 8'hB1);
    chk("R6 disable forces oe low", pad_oe[3], 0);
    wr(P3, 8'hBC);
    chk("R6 oe back after enable", pad_oe[3], 1);
    chk("R9 drive strength", pad_drive[7:6], 3);
    wr(P3, 8'h95);
    chk("R6 mode both no oe", pad_oe[3], 0);
    wr(P3, 8'h9D);
    chk("R6 mode off bit1 oe", pad_oe[3], 1);
    // R7 open drain
    wr(P3, 8'h9B);
    chk("R7 open drain high releases", pad_oe[3], 0);
    wr(P3, 8'h9A);
    chk("R7 open drain low drives", pad_oe[3], 1);
    chk("R7 open drain low level", pad_out[3], 0);
    // R8 inversion
    wr(P3, 8'hD0);
    chk("R8 inverted open drain releases", pad_oe[3], 0);
    chk("R8 inverted driven level", pad_out[3], 1);
    pad_in[3] = 1; #1;
    chk("R8 inverted input level", pin_level[3], 0);
    wr(P3, 8'hD8);
    chk("R8 normal input level", pin_level[3], 1);
    wr(P3, 8'h50);
    rd(P3, 8'h58, "R4 bank 5 readback");
    // R5 address window
    wr('h158, 8'h8F);
    rd('h158, 8'h00, "R5 read above window");
    rd('h14F, 8'h00, "R5 read below window");
    rd('h150, 8'h00, "R5 pin 0 untouched");
    wr('h150, 8'h8F);
    rd('h150, 8'h0F, "R5 pin 0 bank 0");
    wr('h157, 8'h40);
    rd('h157, 8'h40, "R5 last pin select");
    // R10 translation
    ext_pin_num = 0; #1;
    chk("R10 zero rejected", ext_valid, 0);
    ext_pin_num = 1; #1;
    chk("R10 one valid", {ext_valid, 6'(ext_idx)}, 7'h40);
    ext_pin_num = 8; #1;
    chk("R10 max valid", {ext_valid, 6'(ext_idx)}, 7'h47);
    ext_pin_num = 9; #1;
    chk("R10 above max rejected", {ext_valid, 6'(ext_idx)}, 0);
    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule